// File: doc/BRIEF.md
# Three-Bank Interrupt Cause Aggregator

The block gathers single-cycle event pulses from three sources (receive, transmit and miscellaneous) into three identical 32-bit sticky cause banks. Each bank has its own mask. Each bank can be switched at run time between two ways of acknowledging a cause: software writes ones to clear the bits it has handled, or the bits are cleared by reading them. A three-bit summary register keeps one bit per bank that has an unmasked cause pending. Reading the summary register clears it, and the summary has its own mask. Together they drive a single level-sensitive interrupt line.

Software reaches every register through a flat word-addressed port. A read returns data combinationally in the cycle that `rd_en` is high, and any clear caused by that read takes effect at the following clock edge. Bank `b` (0 = receive, 1 = transmit, 2 = miscellaneous) occupies word addresses `8*b` to `8*b+4`. The summary registers sit at addresses 24 and 25. The transmit bank's usual layout is a summary done flag in bit 0 and per-channel done flags for channels 0 to 23 in the bits above it. That layout is a convention for software only: the hardware treats all bits alike.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset, every cause and summary bit is 0, every bank mask reads 0xFFFFFFFF, every bank is in write-one-to-clear mode (mode reads 0), the summary mask reads 7, and `irq` is low.
- R2: An event pulse on bit i of a bank sets cause bit i at the next edge, and the bit holds until it is cleared. The masked view (offset 3) reads cause AND NOT mask.
- R3: A write to offset 1 (mask set) ORs the write data into the bank mask, and offset 1 reads the mask back. A write to offset 2 (mask clear) clears only the mask bits that are 1 in the write data. Offset 2 reads as 0.
- R4: In write-one-to-clear mode, a write to offset 0 clears each cause bit whose write-data bit is 1 and leaves the other bits alone. Reads do not clear. An event on the same cycle as a clear leaves the bit set.
- R5: Write-data bit 0 of a write to offset 4 selects the mode: all ones gives clear-on-read, zero gives write-one-to-clear. Offset 4 reads all ones or all zeros. In clear-on-read mode, a read of offset 0 clears exactly the bits it returned, so an event in the same cycle stays pending, and writes to offset 0 are ignored.
- R6: Summary bit b (bit 0 receive, bit 1 transmit, bit 2 miscellaneous; address 24) is set at the edge after bank b holds any unmasked cause. It stays set until it is read, whatever the summary mask holds.
- R7: A read of address 24 clears the bits it returned. A bit whose bank is still pending is set again at the same edge.
- R8: A write to address 25 loads the summary mask from write-data bits 2:0, and address 25 reads the mask back. `irq` is high exactly when some summary bit is set and its mask bit is 0.
- R9: Unused offsets (5 to 7 of a bank, and 26 to 31) read as 0. With `rd_en` low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; also triggers clear-on-read side effects |
| rd_data | output | 32 | Read data, valid while rd_en is high |
| evt_rx | input | 32 | Receive event pulses, one per bit |
| evt_tx | input | 32 | Transmit event pulses, one per bit |
| evt_misc | input | 32 | Miscellaneous event pulses, one per bit |
| irq | output | 1 | Interrupt line, level high |

## Verification
A corrupted cause or mask bit shows up one edge later in the masked view. It shows up two edges after the event in the summary register and on `irq`, because the summary is registered while the bank pending term is combinational. A lost clear, or a clear applied in the wrong mode, is visible at the next read of offset 0. A summary that was not cleared by a read stays visible on the second consecutive read of address 24 once the bank has been drained. The bench sweeps every bit of every bank and then uses directed sequences for same-cycle event and clear collisions.

// File: rtl/irq_cause_agg.sv
module irq_cause_agg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] evt_rx,
  input  logic [W-1:0] evt_tx,
  input  logic [W-1:0] evt_misc,
  output logic         irq
);
  localparam int NB = 3;
  localparam logic [2:0] OFF_CAUSE = 3'd0;
  localparam logic [2:0] OFF_MSET  = 3'd1;
  localparam logic [2:0] OFF_MCLR  = 3'd2;
  localparam logic [2:0] OFF_MVIEW = 3'd3;
  localparam logic [2:0] OFF_MODE  = 3'd4;
  localparam logic [1:0] GRP_SUM   = 2'd3;

  logic [W-1:0]  cause [NB];
  logic [W-1:0]  mask  [NB];
  logic [W-1:0]  evt   [NB];
  logic [NB-1:0] mode, pend, sum, smask;

  wire [1:0] grp = addr[4:3];
  wire [2:0] off = addr[2:0];

  assign evt[0] = evt_rx;
  assign evt[1] = evt_tx;
  assign evt[2] = evt_misc;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    wire sel   = (grp == 2'(b));
    wire w_hit = wr_en && sel;
    wire c_hit = sel && (off == OFF_CAUSE);
    wire [W-1:0] clr = (!mode[b] && wr_en && c_hit) ? wr_data :
                       ( mode[b] && rd_en && c_hit) ? cause[b] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cause[b] <= '0;
        mask[b]  <= '1;
        mode[b]  <= 1'b0;
      end else begin
        cause[b] <= (cause[b] & ~clr) | evt[b];
        if (w_hit && off == OFF_MSET)      mask[b] <= mask[b] | wr_data;
        else if (w_hit && off == OFF_MCLR) mask[b] <= mask[b] & ~wr_data;
        if (w_hit && off == OFF_MODE)      mode[b] <= wr_data[0];
      end
    end

    assign pend[b] = |(cause[b] & ~mask[b]);
  end

  wire sum_rd = rd_en && grp == GRP_SUM && off == 3'd0;
  wire smk_wr = wr_en && grp == GRP_SUM && off == 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      smask <= '1;
    end else begin
      sum <= (sum & ~(sum_rd ? sum : '0)) | pend;
      if (smk_wr) smask <= wr_data[NB-1:0];
    end
  end

  assign irq = |(sum & ~smask);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (grp == GRP_SUM) begin
        if (off == 3'd0)      rd_data = {{(W-NB){1'b0}}, sum};
        else if (off == 3'd1) rd_data = {{(W-NB){1'b0}}, smask};
      end else begin
        for (int b = 0; b < NB; b++) begin
          if (grp == 2'(b)) begin
            case (off)
              OFF_CAUSE: rd_data = cause[b];
              OFF_MSET:  rd_data = mask[b];
              OFF_MVIEW: rd_data = cause[b] & ~mask[b];
              OFF_MODE:  rd_data = {W{mode[b]}};
              default:   rd_data = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   addr,
  input logic         wr_en,
  input logic         rd_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] evt_rx,
  input logic [W-1:0] cause0,
  input logic [W-1:0] mask0,
  input logic         mode0,
  input logic [2:0]   pend,
  input logic [2:0]   sum,
  input logic [2:0]   smask,
  input logic         irq
);
  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rx != '0) |=> ((cause0 & $past(evt_rx)) == $past(evt_rx)));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd1) |=> ((mask0 & $past(wr_data)) == $past(wr_data)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd2) |=> ((mask0 & $past(wr_data)) == '0));

  // R5
  cor_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 && wr_en && !rd_en && addr == 5'd0 && evt_rx == '0) |=> (cause0 == $past(cause0)));

  // R7
  sum_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'd24 && pend == 3'b000) |=> (sum == 3'b000));

  // R8
  irq_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smask == 3'b111) |-> !irq);
endmodule

bind irq_cause_agg irq_cause_agg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .evt_rx(evt_rx), .cause0(cause[0]), .mask0(mask[0]),
  .mode0(mode[0]), .pend(pend), .sum(sum), .smask(smask), .irq(irq)
);

// File: tb/sim_irq_cause_agg.sv
module sim_irq_cause_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [31:0] evt_rx = '0, evt_tx = '0, evt_misc = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  irq_cause_agg #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .evt_rx(evt_rx), .evt_tx(evt_tx),
    .evt_misc(evt_misc), .irq(irq)
  );

  localparam logic [4:0] A_SUM = 5'd24, A_SMASK = 5'd25;

  function automatic logic [4:0] ba(int b, int o);
    return 5'(b * 8 + o);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(int b, logic [31:0] v);
    @(negedge clk);
    if (b == 0) evt_rx = v; else if (b == 1) evt_tx = v; else evt_misc = v;
    @(negedge clk); evt_rx = '0; evt_tx = '0; evt_misc = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    rd(ba(0, 0), d); chk("R1 rx cause", d, 32'h0);
    rd(ba(1, 1), d); chk("R1 tx mask", d, 32'hFFFF_FFFF);
    rd(ba(2, 4), d); chk("R1 misc mode", d, 32'h0);
    rd(A_SMASK, d);  chk("R1 summary mask", d, 32'h7);
    rd(A_SUM, d);    chk("R1 summary", d, 32'h0);

    // R9 unused offsets and idle read port
    rd(ba(2, 2), d); chk("R9 mask-clear reads zero", d, 32'h0);
    rd(5'd30, d);    chk("R9 unused address", d, 32'h0);
    #1 chk("R9 idle rd_data", rd_data, 32'h0);

    // Sweep every bit of every bank
    wr(A_SMASK, 32'h0);
    for (int b = 0; b < 3; b++) begin
      wr(ba(b, 2), 32'hFFFF_FFFF);
      for (int i = 0; i < 32; i++) begin
        logic [31:0] bit_v;
        logic [31:0] sbit;
        bit_v = 32'h1 << i;
        sbit  = 32'h1 << b;
        pulse(b, bit_v);
        rd(ba(b, 0), d); chk("R2 cause set", d, bit_v);
        chk("R8 irq raised", 32'(irq), 32'h1);
        rd(ba(b, 3), d); chk("R2 masked view", d, bit_v);
        rd(A_SUM, d);    chk("R6 summary bit", d, sbit);
        wr(ba(b, 0), bit_v);
        rd(ba(b, 0), d); chk("R4 w1c clear", d, 32'h0);
        rd(A_SUM, d);    chk("R7 summary sticky until read", d, sbit);
        rd(A_SUM, d);    chk("R7 summary cleared by read", d, 32'h0);
        chk("R8 irq dropped", 32'(irq), 32'h0);
      end
    end

    // R3 mask set and clear on the receive bank
    wr(ba(0, 1), 32'hFFFF_FFFF);
    wr(ba(0, 2), 32'hFFFF_0000);
    rd(ba(0, 1), d); chk("R3 mask after clear", d, 32'h0000_FFFF);
    pulse(0, 32'h0001_0001);
    rd(ba(0, 3), d); chk("R2 masked view partial", d, 32'h0001_0000);
    rd(ba(0, 0), d); chk("R2 raw cause", d, 32'h0001_0001);
    wr(ba(0, 2), 32'h1);
    rd(ba(0, 1), d); chk("R3 single clear", d, 32'h0000_FFFE);
    wr(ba(0, 1), 32'h8000_0000);
    rd(ba(0, 1), d); chk("R3 set ORs", d, 32'h8000_FFFE);
    wr(ba(0, 0), 32'hFFFF_FFFF);
    rd(A_SUM, d); rd(A_SUM, d);
    chk("R7 summary drained", d, 32'h0);

    // R4 partial clear, read does not clear, event beats clear
    pulse(0, 32'h18);
    wr(ba(0, 0), 32'h8);
    rd(ba(0, 0), d); chk("R4 partial clear", d, 32'h10);
    rd(ba(0, 0), d); chk("R4 read keeps bits", d, 32'h10);
    @(negedge clk); addr = ba(0, 0); wr_data = 32'h10; wr_en = 1'b1; evt_rx = 32'h10;
    @(negedge clk); wr_en = 1'b0; evt_rx = '0;
    rd(ba(0, 0), d); chk("R4 event wins over clear", d, 32'h10);
    wr(ba(0, 0), 32'h10);
    rd(ba(0, 0), d); chk("R4 cleared", d, 32'h0);

    // R5 clear-on-read mode
    wr(ba(0, 4), 32'hFFFF_FFFF);
    rd(ba(0, 4), d); chk("R5 mode readback", d, 32'hFFFF_FFFF);
    pulse(0, 32'h5);
    wr(ba(0, 0), 32'hFFFF_FFFF);
    @(negedge clk); addr = ba(0, 0); rd_en = 1'b1; evt_rx = 32'h2; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0; evt_rx = '0;
    chk("R5 write ignored, read value", d, 32'h5);
    rd(ba(0, 0), d); chk("R5 same-cycle event kept", d, 32'h2);
    rd(ba(0, 0), d); chk("R5 cleared by read", d, 32'h0);
    wr(ba(0, 4), 32'h0);
    rd(ba(0, 4), d); chk("R5 back to w1c", d, 32'h0);

    // R8 summary mask on the transmit bank
    rd(A_SUM, d);
    pulse(1, 32'h20);
    wr(A_SMASK, 32'h7);
    chk("R8 irq masked", 32'(irq), 32'h0);
    rd(A_SMASK, d); chk("R8 smask readback", d, 32'h7);
    rd(A_SUM, d);   chk("R6 summary ignores mask", d, 32'h2);
    wr(A_SMASK, 32'h5);
    chk("R8 irq unmasked", 32'(irq), 32'h1);
    wr(A_SMASK, 32'h2);
    chk("R8 other bits unmasked only", 32'(irq), 32'h0);
    wr(ba(1, 0), 32'h20);
    rd(A_SUM, d); rd(A_SUM, d);
    chk("R7 tx summary drained", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule